// File: doc/BRIEF.md
# Pin Data Port with Atomic Set, Clear and Toggle

This block holds the output levels and the direction of a bank of general-purpose pins and makes them reachable over a simple memory-mapped register bus. Software can load the whole output word at once. It can also write a mask to one of three write-only alias addresses to set, clear or invert only the selected pins in a single bus write. Because no read-modify-write is needed, two agents that each own different pins cannot overwrite each other's changes.

The pin inputs pass through a two-flop synchroniser. The result can be read as an input word, one bit per pin. A direction word chooses, pin by pin, whether the block drives the pad. The output level goes to the pad all the time, whatever the direction. A value written before a pin is switched to output is therefore on the pad from the first cycle its enable is high. Reads return data on the clock edge after the read request.

Top module: `gpio_data_port`

## Requirements
- R1: After reset the output word is 0, the direction word is 0, and every pin enable is low.
- R2: A write to address 0x00 loads the output word with the write data. A read of 0x00 returns the output word, and the pin outputs carry it on the cycle after the write.
- R3: A write to address 0x04 sets each output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to address 0x08 clears each output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to address 0x0C inverts each output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: A read of address 0x10 returns the pin levels after a two-flop synchroniser. A level held for two rising edges is visible to a read issued after those edges.
- R7: A write to address 0x14 loads the direction word, and a read of it returns that word. A bit of 1 raises that pin's output enable and a bit of 0 lowers it. The enables change only after such a write.
- R8: The pin outputs always carry the output word, whatever the direction. A pin whose output value was written earlier shows that value on the same cycle its enable rises.
- R9: Reads of 0x04, 0x08, 0x0C and of any unmapped address return zero.
- R10: Writes to 0x10 or to an unmapped address change neither the output word nor the direction word.
- R11: Read data appears on the rising edge where the read enable is sampled high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte address of the register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data or pin mask |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| pinIn | input | 32 | Pad input levels (asynchronous) |
| pinOut | output | 32 | Pad output levels |
| pinOe | output | 32 | Pad output enables |

## Verification
On every cycle, the assertions check how each kind of write changes the pin outputs: a load, a set, a clear or a toggle. They also check that the outputs and enables stay still when no write targets them, and that writes to the input or unmapped addresses leave them alone. The directed scenarios are the only place several things are shown. One is the value carried through the synchroniser into the input word. Another is that the alias and unmapped addresses read as zero. The rest are the reset state and the order in which a preloaded pin is switched to output, which relies on a loopback pad model with forced external levels.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_OUT = 8'h00;
  localparam logic [ADDR_W-1:0] A_SET = 8'h04;
  localparam logic [ADDR_W-1:0] A_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] A_TGL = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IN  = 8'h10;
  localparam logic [ADDR_W-1:0] A_DIR = 8'h14;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_OUT  = 2'd1,
    RD_IN   = 2'd2,
    RD_DIR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrSet;
    logic   wrClr;
    logic   wrTgl;
    logic   wrDir;
    logic   rdStb;
    rdSel_e rdSel;
  } portStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output portStrobe_t       stb
);
  always_comb begin
    stb       = '0;
    stb.rdStb = rdEn;
    stb.rdSel = RD_ZERO;
    if (wrEn) begin
      unique case (regAddr)
        A_OUT:   stb.wrOut = 1'b1;
        A_SET:   stb.wrSet = 1'b1;
        A_CLR:   stb.wrClr = 1'b1;
        A_TGL:   stb.wrTgl = 1'b1;
        A_DIR:   stb.wrDir = 1'b1;
        default: ;
      endcase
    end
    unique case (regAddr)
      A_OUT:   stb.rdSel = RD_OUT;
      A_IN:    stb.rdSel = RD_IN;
      A_DIR:   stb.rdSel = RD_DIR;
      default: stb.rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         stb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] outWord,
  output logic [NUM_PINS-1:0] dirWord
);
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] inWord;
  logic [NUM_PINS-1:0] outNext;
  logic [NUM_PINS-1:0] rdMux;

  // synchroniser chain, one stage per generate step
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= pinIn;
      else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end
  assign inWord = syncChain[SYNC_STAGES-1];

  always_comb begin
    outNext = outWord;
    if (stb.wrOut) outNext = wrData;
    if (stb.wrSet) outNext = outWord | wrData;
    if (stb.wrClr) outNext = outWord & ~wrData;
    if (stb.wrTgl) outNext = outWord ^ wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
      dirWord <= '0;
    end else begin
      outWord <= outNext;
      if (stb.wrDir) dirWord <= wrData;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_OUT:  rdMux = outWord;
      RD_IN:   rdMux = inWord;
      RD_DIR:  rdMux = dirWord;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdStb) rdData <= rdMux;
  end
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                wrEn,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic                rdEn,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  portStrobe_t stb;

  gpio_port_ctrl u_ctrl (
    .regAddr(regAddr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .stb(stb)
  );

  gpio_port_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wrData(wrData),
    .pinIn(pinIn),
    .rdData(rdData),
    .outWord(pinOut),
    .dirWord(pinOe)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                wrEn,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe
);
  logic hitOut, hitSet, hitClr, hitTgl, hitDir, hitNone;
  assign hitOut  = wrEn && regAddr == A_OUT;
  assign hitSet  = wrEn && regAddr == A_SET;
  assign hitClr  = wrEn && regAddr == A_CLR;
  assign hitTgl  = wrEn && regAddr == A_TGL;
  assign hitDir  = wrEn && regAddr == A_DIR;
  assign hitNone = wrEn && !(hitOut || hitSet || hitClr || hitTgl || hitDir);

  // R2
  load_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |=> pinOut == $past(wrData));
  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitSet |=> pinOut == ($past(pinOut) | $past(wrData)));
  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitClr |=> pinOut == ($past(pinOut) & ~$past(wrData)));
  // R5
  toggle_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitTgl |=> pinOut == ($past(pinOut) ^ $past(wrData)));
  // R7
  dir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitDir |=> pinOe == $past(wrData));
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitDir |=> $stable(pinOe));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hitOut || hitSet || hitClr || hitTgl) |=> $stable(pinOut));
  // R10
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitNone |=> $stable(pinOut) && $stable(pinOe));
endmodule

bind gpio_data_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .regAddr(regAddr),
  .wrEn(wrEn),
  .wrData(wrData),
  .pinOut(pinOut),
  .pinOe(pinOe)
);

// File: tb/gpio_data_port_bench.sv
`timescale 1ns/1ps
module gpio_data_port_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   regAddr = '0;
  logic         wrEn = 1'b0;
  logic [N-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [N-1:0] rdData;
  logic [N-1:0] pinIn;
  logic [N-1:0] pinOut;
  logic [N-1:0] pinOe;
  logic [N-1:0] extLevel = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // loopback pad: driven pins read their own level, others see the forced level
  assign pinIn = (pinOe & pinOut) | (~pinOe & extLevel);

  gpio_data_port u_gpio_data_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [N-1:0] v;
    check("R1 pinOut", pinOut, '0);
    check("R1 pinOe", pinOe, '0);
    busRead(8'h14, v);
    check("R1 dir", v, '0);
    busRead(8'h00, v);
    check("R1 out", v, '0);
  endtask

  task automatic testAliases();
    logic [N-1:0] v;
    busWrite(8'h00, 32'h1234_5678);
    check("R2 pins", pinOut, 32'h1234_5678);
    busRead(8'h00, v);
    check("R2 read", v, 32'h1234_5678);
    busWrite(8'h04, 32'h8000_0001);
    check("R3 set", pinOut, 32'h9234_5679);
    busWrite(8'h08, 32'h0000_0678);
    check("R4 clear", pinOut, 32'h9234_5001);
    busWrite(8'h0C, 32'hFFFF_0000);
    check("R5 toggle", pinOut, 32'h6DCB_5001);
    busWrite(8'h0C, 32'h0000_0000);
    check("R5 zero mask", pinOut, 32'h6DCB_5001);
  endtask

  task automatic testZeroReads();
    logic [N-1:0] v;
    busRead(8'h04, v); check("R9 set addr", v, '0);
    busRead(8'h08, v); check("R9 clear addr", v, '0);
    busRead(8'h0C, v); check("R9 toggle addr", v, '0);
    busRead(8'h40, v); check("R9 unmapped", v, '0);
  endtask

  task automatic testIgnoredWrites();
    logic [N-1:0] v;
    busWrite(8'h10, 32'hFFFF_FFFF);
    busWrite(8'h3C, 32'hFFFF_FFFF);
    check("R10 pins", pinOut, 32'h6DCB_5001);
    check("R10 oe", pinOe, '0);
    busRead(8'h00, v);
    check("R10 out", v, 32'h6DCB_5001);
  endtask

  task automatic testInput();
    logic [N-1:0] v;
    @(negedge clk);
    extLevel = 32'hA5A5_0F0F;
    @(negedge clk);
    @(negedge clk);
    busRead(8'h10, v);
    check("R6 input", v, 32'hA5A5_0F0F);
    extLevel = 32'h0000_0000;
    repeat (3) @(negedge clk);
    busRead(8'h10, v);
    check("R6 input low", v, '0);
  endtask

  task automatic testDirection();
    logic [N-1:0] v;
    busWrite(8'h00, 32'h0000_00A5);
    check("R8 value before enable", pinOut, 32'h0000_00A5);
    check("R8 still input", pinOe, '0);
    busWrite(8'h14, 32'h0000_00FF);
    check("R7 oe", pinOe, 32'h0000_00FF);
    check("R8 same cycle", pinOut, 32'h0000_00A5);
    busRead(8'h14, v);
    check("R7 dir read", v, 32'h0000_00FF);
    extLevel = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    busRead(8'h10, v);
    check("R6 mixed loopback", v, 32'hFFFF_FFA5);
    extLevel = '0;
  endtask

  task automatic testReadHold();
    logic [N-1:0] v;
    busRead(8'h14, v);
    @(negedge clk);
    regAddr = 8'h00;
    repeat (2) @(negedge clk);
    check("R11 hold", rdData, 32'h0000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAliases();
    testZeroReads();
    testIgnoredWrites();
    testInput();
    testDirection();
    testReadHold();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule